// File: doc/BRIEF.md
# ADC Serial Output Framer

This block is the digital output side of a sampling converter. A rising edge on an asynchronous convert-start input passes through a synchroniser and an edge detector. The edge captures the parallel sample word, which models the hold instant. The block then waits a fixed conversion delay and sends the held word out on a serial line, most significant bit first. An active-low frame strobe brackets the serial word.

The receive clock is a divided copy of the block clock. The receiver samples the data line on each falling edge of the receive clock while the frame strobe is low. The data line changes only on rising edges. A mode input selects one of two clock behaviours. In continuous mode the receive clock runs at all times. In gated mode it runs only around a word; between words it is floated, which is modelled by driving an output-enable low and holding the clock pin high.

A convert-start edge that arrives while a conversion or transmission is in progress is dropped. Such an edge sets an overrun flag that stays set until reset.

Top module: `adc_serial_framer`

## Requirements
- R1: While reset is held (synchronous, active high) and on the first cycle after it, `frame_n` is 1, `sdata` is 0, `overrun` is 0 and `rclk_oe` is 0.
- R2: A rising edge on `conv_start` while idle starts a conversion. The frame strobe falls no sooner than CONV_CYCLES + RCLK_HALF + SYNC_STAGES block-clock cycles after the input edge, and within 4 + 3*RCLK_HALF further cycles.
- R3: The word sent is the value `sample_in` held when the start edge was detected. Later changes to `sample_in` have no effect on that word.
- R4: The word is WORD_W bits, sent most significant bit first. Each bit is driven on a rising edge of `rclk` and is valid at the following falling edge, while `frame_n` is 0.
- R5: `frame_n` falls on a falling edge of `rclk`, one full receive-clock period (2*RCLK_HALF block cycles) before the first sampling falling edge.
- R6: Exactly WORD_W falling edges of `rclk` occur while the frame strobe is low. `frame_n` returns high on the rising edge RCLK_HALF cycles after the last of them.
- R7: The receive clock toggles every RCLK_HALF block cycles. With `clk_continuous` = 1, `rclk_oe` is 1 and `rclk` toggles at all times.
- R8: With `clk_continuous` = 0, `rclk_oe` is 0 and `rclk` is held at 1 between words, with no toggles.
- R9: A start edge that arrives while a conversion or transmission is in progress produces no extra frame. It also leaves the word in flight unchanged.
- R10: Such a dropped edge sets `overrun` to 1. The flag stays at 1 through later normal words and clears only on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the receive clock is derived from it |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Asynchronous convert-start; a rising edge starts a conversion |
| clk_continuous | input | 1 | 1: receive clock runs at all times; 0: gated per word |
| sample_in | input | WORD_W | Parallel sample from the converter core |
| frame_n | output | 1 | Active-low frame strobe |
| rclk | output | 1 | Receive clock (held high while not enabled) |
| rclk_oe | output | 1 | Receive-clock output enable; 0 models a floated pin |
| sdata | output | 1 | Serial data, MSB first |
| overrun | output | 1 | Sticky flag: a start edge arrived while busy |

## Verification
Each fault in the state shows at the pins within one word. A bad bit counter or shift register gives a wrong received word, or a wrong count of sampling edges inside the frame, when the strobe rises. A sequencer stuck in a state, or stepping at the wrong tick, moves the strobe edges off their expected distances from the sampling edges, or produces no frame before the timeout. A wrong enable state shows as toggles or a lowered `rclk_oe` between words in the wrong mode. A busy check that lets a second edge through shows as an extra frame, a corrupted word or a missing overrun flag.

// File: rtl/adc_sfr_pkg.sv
package adc_sfr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_ALIGN,
    ST_LEAD,
    ST_SEND
  } sfr_state_t;
endpackage

// File: rtl/adc_sfr_sync.sv
// Multi-stage synchroniser followed by a rising-edge detector.
module adc_sfr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] stg;
  logic              last;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= 1'b0;
          else     stg[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[gi] <= 1'b0;
          else     stg[gi] <= stg[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b0;
    else     last <= stg[STAGES-1];
  end

  assign rise_o = stg[STAGES-1] & ~last;
endmodule

// File: rtl/adc_sfr_clkgen.sv
// Free-running receive-clock divider with one-cycle-early edge ticks.
module adc_sfr_clkgen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  output logic rclk_q,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int PERIOD = 2 * HALF;
  localparam int PH_W   = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [PH_W-1:0] ph;

  assign fall_tick = (ph == PH_W'(HALF - 1));
  assign rise_tick = (ph == PH_W'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      rclk_q <= 1'b1;
    end else begin
      ph <= rise_tick ? '0 : ph + 1'b1;
      if (fall_tick)      rclk_q <= 1'b0;
      else if (rise_tick) rclk_q <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_sfr_seq.sv
// Conversion / framing sequencer and output shifter.
module adc_sfr_seq
  import adc_sfr_pkg::*;
#(
  parameter int WORD_W      = 12,
  parameter int CONV_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              mode_cont_i,
  input  logic [WORD_W-1:0] sample_i,
  input  logic              rise_tick,
  input  logic              fall_tick,
  output logic              frame_n_o,
  output logic              sdata_o,
  output logic              oe_o,
  output logic              overrun_o
);
  localparam int CNT_W  = $clog2(CONV_CYCLES) + 1;
  localparam int LEFT_W = $clog2(WORD_W + 1);

  sfr_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [LEFT_W-1:0] left;
  logic [WORD_W-1:0] sh;
  logic              win;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      left      <= '0;
      sh        <= '0;
      win       <= 1'b0;
      frame_n_o <= 1'b1;
      sdata_o   <= 1'b0;
      oe_o      <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      oe_o <= mode_cont_i | win;
      if (start_i && state != ST_IDLE) overrun_o <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            sh    <= sample_i;
            cnt   <= CNT_W'(CONV_CYCLES - 1);
            state <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (cnt == '0) state <= ST_ALIGN;
          else           cnt   <= cnt - 1'b1;
        end
        ST_ALIGN: begin
          if (rise_tick) begin
            win   <= 1'b1;
            state <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (fall_tick) begin
            frame_n_o <= 1'b0;
            left      <= LEFT_W'(WORD_W);
            state     <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (rise_tick) begin
            if (left != '0) begin
              sdata_o <= sh[WORD_W-1];
              sh      <= {sh[WORD_W-2:0], 1'b0};
              left    <= left - 1'b1;
            end else begin
              frame_n_o <= 1'b1;
              sdata_o   <= 1'b0;
              win       <= 1'b0;
              state     <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_serial_framer.sv
module adc_serial_framer #(
  parameter int WORD_W      = 12,
  parameter int CONV_CYCLES = 16,
  parameter int RCLK_HALF   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_start,
  input  logic              clk_continuous,
  input  logic [WORD_W-1:0] sample_in,
  output logic              frame_n,
  output logic              rclk,
  output logic              rclk_oe,
  output logic              sdata,
  output logic              overrun
);
  logic start_edge;
  logic rclk_q;
  logic rise_tick;
  logic fall_tick;

  adc_sfr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (conv_start),
    .rise_o  (start_edge)
  );

  adc_sfr_clkgen #(.HALF(RCLK_HALF)) u_clkgen (
    .clk       (clk),
    .rst       (rst),
    .rclk_q    (rclk_q),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  adc_sfr_seq #(
    .WORD_W      (WORD_W),
    .CONV_CYCLES (CONV_CYCLES)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_edge),
    .mode_cont_i (clk_continuous),
    .sample_i    (sample_in),
    .rise_tick   (rise_tick),
    .fall_tick   (fall_tick),
    .frame_n_o   (frame_n),
    .sdata_o     (sdata),
    .oe_o        (rclk_oe),
    .overrun_o   (overrun)
  );

  assign rclk = rclk_q | ~rclk_oe;
endmodule

// File: rtl/adc_sfr_checker.sv
module adc_sfr_checker #(
  parameter int WORD_W = 12
) (
  input logic clk,
  input logic rst,
  input logic clk_continuous,
  input logic frame_n,
  input logic rclk,
  input logic rclk_oe,
  input logic sdata,
  input logic overrun
);
  localparam int NF_W = $clog2(WORD_W + 2) + 1;

  logic            rclk_d;
  logic            frame_d;
  logic [NF_W-1:0] nfall;

  always_ff @(posedge clk) begin
    if (rst) begin
      rclk_d  <= 1'b1;
      frame_d <= 1'b1;
      nfall   <= '0;
    end else begin
      rclk_d  <= rclk;
      frame_d <= frame_n;
      if (frame_d && !frame_n)                 nfall <= '0;
      else if (rclk_d && !rclk && !frame_d)    nfall <= nfall + 1'b1;
    end
  end

  assert_word_len_R6: assert property (@(posedge clk) disable iff (rst)
    (!frame_d && frame_n) |-> (nfall == NF_W'(WORD_W)));

  assert_data_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
    (!frame_n && !frame_d && !$stable(sdata)) |-> (rclk && !rclk_d));

  assert_gated_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!clk_continuous && !rclk_oe) |-> rclk);

  assert_cont_enabled_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(clk_continuous)) |-> rclk_oe);

  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    $past(overrun) |-> overrun);
endmodule

bind adc_serial_framer adc_sfr_checker #(.WORD_W(WORD_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .clk_continuous (clk_continuous),
  .frame_n        (frame_n),
  .rclk           (rclk),
  .rclk_oe        (rclk_oe),
  .sdata          (sdata),
  .overrun        (overrun)
);

// File: tb/adc_serial_framer_bench.sv
module adc_serial_framer_bench;
  localparam int W    = 12;
  localparam int CONV = 16;
  localparam int HALF = 2;
  localparam int SYNC = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         conv_start = 1'b0;
  logic         clk_continuous = 1'b0;
  logic [W-1:0] sample_in = '0;
  logic         frame_n, rclk, rclk_oe, sdata, overrun;

  adc_serial_framer #(
    .WORD_W(W), .CONV_CYCLES(CONV), .RCLK_HALF(HALF), .SYNC_STAGES(SYNC)
  ) u_adc_serial_framer (
    .clk(clk), .rst(rst), .conv_start(conv_start),
    .clk_continuous(clk_continuous), .sample_in(sample_in),
    .frame_n(frame_n), .rclk(rclk), .rclk_oe(rclk_oe),
    .sdata(sdata), .overrun(overrun)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int vectors = 0;
  int fails   = 0;

  // receiver model
  logic         p_rclk = 1'b1, p_frame = 1'b1;
  logic [W-1:0] shreg = '0, word = '0;
  int bits = 0, nbits = 0, fall_cyc = 0, last_cyc = 0;
  int lead = 0, tail = 0, frames = 0, ends = 0, toggles = 0;

  always @(negedge clk) begin
    if (rst) begin
      p_rclk  <= 1'b1;
      p_frame <= 1'b1;
    end else begin
      if (rclk != p_rclk) toggles <= toggles + 1;
      if (p_frame && !frame_n) begin
        fall_cyc <= cyc; bits <= 0; shreg <= '0; frames <= frames + 1;
      end
      if (p_rclk && !rclk && !p_frame && rclk_oe) begin
        shreg <= {shreg[W-2:0], sdata};
        bits  <= bits + 1;
        if (bits == 0) lead <= cyc - fall_cyc;
        last_cyc <= cyc;
      end
      if (!p_frame && frame_n) begin
        word <= shreg; nbits <= bits; tail <= cyc - last_cyc; ends <= ends + 1;
      end
      p_rclk  <= rclk;
      p_frame <= frame_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [W-1:0] v, input bit chg);
    int e0;
    int t0;
    int k;
    e0 = ends;
    @(negedge clk);
    sample_in  = v;
    conv_start = 1'b1;
    t0 = cyc;
    repeat (4) @(negedge clk);
    conv_start = 1'b0;
    if (chg) sample_in = ~v;
    k = 0;
    while (ends == e0 && k < 600) begin
      @(negedge clk);
      k++;
    end
    @(negedge clk);
    if (k >= 600) chk(1'b0, "R4 timeout", 0, 1);
    if (chg) chk(word == v, "R3 held word", int'(word), int'(v));
    else     chk(word == v, "R4 word", int'(word), int'(v));
    chk(nbits == W, "R6 bit count", nbits, W);
    chk(lead == 2*HALF, "R5 lead", lead, 2*HALF);
    chk(tail == HALF, "R6 tail", tail, HALF);
    chk((fall_cyc - t0) >= CONV + HALF + SYNC &&
        (fall_cyc - t0) <= CONV + 3*HALF + SYNC + 4,
        "R2 start delay", fall_cyc - t0, CONV + HALF + SYNC);
  endtask

  task automatic idle_gated_check();
    int t0;
    repeat (6) @(negedge clk);
    chk(rclk_oe == 1'b0, "R8 oe idle", int'(rclk_oe), 0);
    chk(rclk == 1'b1, "R8 rclk idle", int'(rclk), 1);
    t0 = toggles;
    repeat (16) @(negedge clk);
    chk(toggles == t0, "R8 no toggles", toggles - t0, 0);
  endtask

  initial begin
    int t0;
    int f0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(frame_n == 1'b1, "R1 frame_n", int'(frame_n), 1);
    chk(sdata == 1'b0, "R1 sdata", int'(sdata), 0);
    chk(overrun == 1'b0, "R1 overrun", int'(overrun), 0);
    chk(rclk_oe == 1'b0, "R1 rclk_oe", int'(rclk_oe), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(frame_n == 1'b1 && rclk_oe == 1'b0, "R1 after release", int'(frame_n), 1);

    // gated mode sweep
    send_word(12'h000, 1'b0);
    idle_gated_check();
    send_word(12'hFFF, 1'b0);
    send_word(12'hA5A, 1'b0);
    send_word(12'h5A5, 1'b0);
    for (int i = 0; i < W; i++) send_word(W'(1) << i, 1'b0);
    for (int i = 0; i < 16; i++) send_word(W'(i * 257 + 3), 1'b0);
    idle_gated_check();

    // R3 hold: input changes after the start edge
    send_word(12'h3C1, 1'b1);
    send_word(12'hE07, 1'b1);

    // R7 continuous mode
    @(negedge clk);
    clk_continuous = 1'b1;
    repeat (3) @(negedge clk);
    chk(rclk_oe == 1'b1, "R7 oe continuous", int'(rclk_oe), 1);
    t0 = toggles;
    repeat (40) @(negedge clk);
    chk(toggles - t0 == 40 / HALF, "R7 toggle rate", toggles - t0, 40 / HALF);
    send_word(12'h123, 1'b0);
    send_word(12'hFED, 1'b0);
    for (int i = 0; i < 8; i++) send_word(W'(i * 511 + 1), 1'b0);
    t0 = toggles;
    repeat (20) @(negedge clk);
    chk(toggles - t0 == 20 / HALF, "R7 toggles between words", toggles - t0, 20 / HALF);
    chk(rclk_oe == 1'b1, "R7 oe between words", int'(rclk_oe), 1);

    // R9 / R10 overrun
    clk_continuous = 1'b0;
    repeat (4) @(negedge clk);
    chk(overrun == 1'b0, "R10 clear before", int'(overrun), 0);
    f0 = frames;
    t0 = ends;
    sample_in  = 12'h6B9;
    conv_start = 1'b1;
    repeat (4) @(negedge clk);
    conv_start = 1'b0;
    while (frame_n) @(negedge clk);
    repeat (6) @(negedge clk);
    sample_in  = 12'h000;
    conv_start = 1'b1;
    repeat (4) @(negedge clk);
    conv_start = 1'b0;
    while (ends == t0) @(negedge clk);
    @(negedge clk);
    chk(word == 12'h6B9, "R9 word unchanged", int'(word), 'h6B9);
    chk(overrun == 1'b1, "R10 overrun set", int'(overrun), 1);
    repeat (150) @(negedge clk);
    chk(frames == f0 + 1, "R9 no extra frame", frames - f0, 1);
    send_word(12'h0F0, 1'b0);
    chk(overrun == 1'b1, "R10 sticky", int'(overrun), 1);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(overrun == 1'b0, "R10 cleared by reset", int'(overrun), 0);
    chk(frame_n == 1'b1 && sdata == 1'b0, "R1 second reset", int'(frame_n), 1);
    send_word(12'h81E, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule